// File: doc/BRIEF.md
# Interrupt Gate Entry Sequencer

This block runs the frame-building part of interrupt and exception entry once the event has been accepted and its gate has been fetched. A one-cycle `start` presents the gate's kind (interrupt or trap), its target privilege, the handler's code selector and entry offset, and a snapshot of the interrupted context: privilege level, stack selector, stack pointer, flags, code selector, instruction offset and an optional error code. The block compares privileges first. A target less privileged than the current level raises a protection fault and writes nothing. A more privileged target moves the frame onto an inner stack, whose selector and pointer arrive on a dedicated input pair.

The return frame is written to memory one 32-bit word per accepted transfer over a valid/ready write port. Each address sits 4 below the previous one. The frame is three, four, five or six words long, depending on whether the stack switches and whether an error code applies. When the last word is accepted, the block loads the new privilege level, code selector, entry offset, flags and stack values, and pulses `done`. An interrupt gate clears the interrupt-enable flag and a trap gate preserves it.

Top module: `irq_gate_entry`

## Requirements
- R1: After reset, and until the first `start`, `busy`, `wr_valid`, `done` and `gp_fault` are low and all `new_*` outputs are zero.
- R2: When `gate_dpl` is numerically greater than `cur_cpl`, `gp_fault` is high for exactly one cycle, the cycle after `start`. No write is issued and the `new_*` outputs keep their previous values.
- R3: When `gate_dpl` equals `cur_cpl`, the frame is built on `cur_esp`. The words are the flags, the code word and the instruction offset, in that order, at addresses `cur_esp-4`, `-8` and `-12`, and no stack words are written.
- R4: When `gate_dpl` is numerically less than `cur_cpl`, the frame starts at `inner_esp`. It first writes the old stack selector, then the old `cur_esp`, and then the flags, code word and instruction offset, for five words in all.
- R5: When `has_err` is high, `err_code` is written as one extra word after the instruction offset, at the lowest address of the frame.
- R6: Selector words are zero in bits 31:16. The saved code word carries `cur_cs` bits 15:2 and `cur_cpl` in bits 1:0. The saved stack word carries `cur_ss` in bits 15:0.
- R7: The flags word written to the frame is the unmodified `cur_eflags`. In `new_eflags`, bit 9 (interrupt enable) is cleared for an interrupt gate (`gate_is_trap`=0) and copied unchanged for a trap gate (`gate_is_trap`=1). All other bits are copied unchanged.
- R8: A word is written only on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_addr` and `wr_data` hold. Each accepted word's address is 4 below the previous one.
- R9: `done` is high for one cycle, the cycle after the last word is accepted. From then on `new_cpl`=`gate_dpl` and `new_cs`=`gate_cs`, `new_eip`=`gate_eip`, and `new_esp` is the address of the last word written. `new_ss` is `inner_ss` if the stack switched and `cur_ss` if it did not.
- R10: A `start` while `busy` is high is ignored. The frame in progress uses only the values captured at the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request to run an entry with the values presented |
| gate_is_trap | input | 1 | 1: trap gate, 0: interrupt gate |
| gate_dpl | input | 2 | Privilege of the handler code |
| gate_cs | input | 16 | Handler code selector |
| gate_eip | input | 32 | Handler entry offset |
| cur_cpl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags |
| cur_cs | input | 16 | Current code selector |
| cur_eip | input | 32 | Return instruction offset |
| has_err | input | 1 | An error code is to be pushed |
| err_code | input | 32 | Error code value |
| inner_ss | input | 16 | Stack selector for the target level |
| inner_esp | input | 32 | Stack pointer for the target level |
| wr_ready | input | 1 | Memory accepts the current word |
| wr_valid | output | 1 | A frame word is presented |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Frame word |
| busy | output | 1 | A frame is being written |
| done | output | 1 | One-cycle pulse, entry complete |
| gp_fault | output | 1 | One-cycle pulse, privilege check failed |
| new_cpl | output | 2 | Privilege level after entry |
| new_cs | output | 16 | Code selector after entry |
| new_eip | output | 32 | Instruction offset after entry |
| new_eflags | output | 32 | Flags after entry |
| new_ss | output | 16 | Stack selector after entry |
| new_esp | output | 32 | Stack pointer after entry |

## Verification
The entry sequence is exercised with privilege pairs that give the three outcomes: equal levels, an inward switch, and an outward target that must fault. Error codes are present in some runs and absent in others, so that all four frame lengths appear. An interrupt gate and a trap gate are each entered with the flags' enable bit set, which shows whether the bit is cleared in the new flags while the pushed copy stays intact. One run stalls the write port and re-asserts `start` with altered inputs mid-frame, so it tells a design that holds its word and ignores the second request from one that skips, repeats or re-captures.

// File: rtl/irq_gate_entry_pkg.sv
package irq_gate_entry_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PUSH = 1'b1
  } entry_state_e;

  // Frame slots in push order; the sequencer walks them upward.
  typedef enum logic [2:0] {
    SL_SS    = 3'd0,
    SL_ESP   = 3'd1,
    SL_FLAGS = 3'd2,
    SL_CS    = 3'd3,
    SL_EIP   = 3'd4,
    SL_ERR   = 3'd5
  } frame_slot_e;

endpackage

// File: rtl/gate_priv_check.sv
module gate_priv_check #(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] tgt_pl,
  input  logic [PL_W-1:0] cur_pl,
  output logic            fault,
  output logic            go_inner
);

  // Larger number means less privilege.
  always_comb begin
    fault    = (tgt_pl > cur_pl);
    go_inner = (tgt_pl < cur_pl);
  end

endmodule

// File: rtl/gate_frame_mux.sv
module gate_frame_mux
  import irq_gate_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16,
  parameter int PL_W   = 2
) (
  input  frame_slot_e       slot,
  input  logic [SEL_W-1:0]  old_ss,
  input  logic [DATA_W-1:0] old_esp,
  input  logic [DATA_W-1:0] old_flags,
  input  logic [SEL_W-1:0]  old_cs,
  input  logic [PL_W-1:0]   old_pl,
  input  logic [DATA_W-1:0] old_eip,
  input  logic [DATA_W-1:0] err,
  output logic [DATA_W-1:0] word
);

  localparam int PAD_W = DATA_W - SEL_W;

  logic unused_cs_rpl;
  assign unused_cs_rpl = ^old_cs[PL_W-1:0];

  always_comb begin
    unique case (slot)
      SL_SS:    word = {{PAD_W{1'b0}}, old_ss};
      SL_ESP:   word = old_esp;
      SL_FLAGS: word = old_flags;
      SL_CS:    word = {{PAD_W{1'b0}}, old_cs[SEL_W-1:PL_W], old_pl};
      SL_EIP:   word = old_eip;
      SL_ERR:   word = err;
      default:  word = '0;
    endcase
  end

endmodule

// File: rtl/irq_gate_entry.sv
module irq_gate_entry
  import irq_gate_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16,
  parameter int PL_W   = 2,
  parameter int IF_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              gate_is_trap,
  input  logic [PL_W-1:0]   gate_dpl,
  input  logic [SEL_W-1:0]  gate_cs,
  input  logic [DATA_W-1:0] gate_eip,
  input  logic [PL_W-1:0]   cur_cpl,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic [DATA_W-1:0] cur_esp,
  input  logic [DATA_W-1:0] cur_eflags,
  input  logic [SEL_W-1:0]  cur_cs,
  input  logic [DATA_W-1:0] cur_eip,
  input  logic              has_err,
  input  logic [DATA_W-1:0] err_code,
  input  logic [SEL_W-1:0]  inner_ss,
  input  logic [DATA_W-1:0] inner_esp,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              gp_fault,
  output logic [PL_W-1:0]   new_cpl,
  output logic [SEL_W-1:0]  new_cs,
  output logic [DATA_W-1:0] new_eip,
  output logic [DATA_W-1:0] new_eflags,
  output logic [SEL_W-1:0]  new_ss,
  output logic [DATA_W-1:0] new_esp
);

  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(DATA_W / 8);
  localparam logic [DATA_W-1:0] IF_MASK    = DATA_W'(1) << IF_BIT;

  // ---------------- privilege decision on live inputs
  logic chk_fault, chk_inner;

  gate_priv_check #(.PL_W(PL_W)) u_priv (
    .tgt_pl   (gate_dpl),
    .cur_pl   (cur_cpl),
    .fault    (chk_fault),
    .go_inner (chk_inner)
  );

  // ---------------- sequencer state
  entry_state_e      state_q, state_d;
  frame_slot_e       slot_q, slot_d;
  frame_slot_e       last_q, last_d;
  logic [DATA_W-1:0] sp_q, sp_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;

  // captured context
  logic              trap_q, inner_q;
  logic [PL_W-1:0]   tpl_q, opl_q;
  logic [SEL_W-1:0]  gcs_q, oss_q, ocs_q, iss_q;
  logic [DATA_W-1:0] geip_q, oesp_q, oflg_q, oeip_q, err_q;

  logic cap_en, fin_en, push_fire;

  always_comb begin
    cap_en    = (state_q == ST_IDLE) && start && !chk_fault;
    push_fire = (state_q == ST_PUSH) && wr_ready;
    fin_en    = push_fire && (slot_q == last_q);
  end

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    last_d  = last_q;
    sp_d    = sp_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (chk_fault) begin
            fault_d = 1'b1;
          end else begin
            state_d = ST_PUSH;
            slot_d  = chk_inner ? SL_SS : SL_FLAGS;
            last_d  = has_err ? SL_ERR : SL_EIP;
            sp_d    = chk_inner ? inner_esp : cur_esp;
          end
        end
      end
      ST_PUSH: begin
        if (push_fire) begin
          sp_d = sp_q - WORD_BYTES;
          if (fin_en) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            slot_d = frame_slot_e'(slot_q + 3'd1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= SL_SS;
      last_q  <= SL_EIP;
      sp_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      last_q  <= last_d;
      sp_q    <= sp_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0; inner_q <= 1'b0;
      tpl_q  <= '0;   opl_q   <= '0;
      gcs_q  <= '0;   oss_q   <= '0; ocs_q <= '0; iss_q <= '0;
      geip_q <= '0;   oesp_q  <= '0; oflg_q <= '0; oeip_q <= '0; err_q <= '0;
    end else if (cap_en) begin
      trap_q <= gate_is_trap; inner_q <= chk_inner;
      tpl_q  <= gate_dpl;     opl_q   <= cur_cpl;
      gcs_q  <= gate_cs;      oss_q   <= cur_ss;  ocs_q <= cur_cs; iss_q <= inner_ss;
      geip_q <= gate_eip;     oesp_q  <= cur_esp; oflg_q <= cur_eflags;
      oeip_q <= cur_eip;      err_q   <= err_code;
    end
  end

  // ---------------- result registers, loaded on the final accepted word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_cpl    <= '0;
      new_cs     <= '0;
      new_eip    <= '0;
      new_eflags <= '0;
      new_ss     <= '0;
      new_esp    <= '0;
    end else if (fin_en) begin
      new_cpl    <= tpl_q;
      new_cs     <= gcs_q;
      new_eip    <= geip_q;
      new_eflags <= trap_q ? oflg_q : (oflg_q & ~IF_MASK);
      new_ss     <= inner_q ? iss_q : oss_q;
      new_esp    <= sp_q - WORD_BYTES;
    end
  end

  // ---------------- frame word selection and port drive
  gate_frame_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .PL_W(PL_W)) u_mux (
    .slot      (slot_q),
    .old_ss    (oss_q),
    .old_esp   (oesp_q),
    .old_flags (oflg_q),
    .old_cs    (ocs_q),
    .old_pl    (opl_q),
    .old_eip   (oeip_q),
    .err       (err_q),
    .word      (wr_data)
  );

  always_comb begin
    wr_valid = (state_q == ST_PUSH);
    wr_addr  = sp_q - WORD_BYTES;
    busy     = (state_q != ST_IDLE);
    done     = done_q;
    gp_fault = fault_q;
  end

  // ---------------- assertions
  a_r2_fault_no_write : assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (!wr_valid && !busy));

  a_r8_hold_stalled : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r8_addr_step : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !done_d) |=> (wr_addr == $past(wr_addr) - WORD_BYTES));

  a_r9_done_alone : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, gp_fault, wr_valid}));

  a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_if_cleared : assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trap_q) |-> !new_eflags[IF_BIT]);

  a_r10_capture_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(oeip_q) && $stable(tpl_q)));

endmodule

// File: tb/irq_gate_entry_bench.sv
module irq_gate_entry_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        gate_is_trap = 1'b0;
  logic [1:0]  gate_dpl = '0;
  logic [15:0] gate_cs = '0;
  logic [31:0] gate_eip = '0;
  logic [1:0]  cur_cpl = '0;
  logic [15:0] cur_ss = '0;
  logic [31:0] cur_esp = '0;
  logic [31:0] cur_eflags = '0;
  logic [15:0] cur_cs = '0;
  logic [31:0] cur_eip = '0;
  logic        has_err = 1'b0;
  logic [31:0] err_code = '0;
  logic [15:0] inner_ss = '0;
  logic [31:0] inner_esp = '0;
  logic        wr_ready = 1'b1;
  logic        wr_valid, busy, done, gp_fault;
  logic [31:0] wr_addr, wr_data, new_eip, new_eflags, new_esp;
  logic [15:0] new_cs, new_ss;
  logic [1:0]  new_cpl;

  irq_gate_entry u_irq_gate_entry (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_is_trap(gate_is_trap),
    .gate_dpl(gate_dpl), .gate_cs(gate_cs), .gate_eip(gate_eip),
    .cur_cpl(cur_cpl), .cur_ss(cur_ss), .cur_esp(cur_esp),
    .cur_eflags(cur_eflags), .cur_cs(cur_cs), .cur_eip(cur_eip),
    .has_err(has_err), .err_code(err_code), .inner_ss(inner_ss),
    .inner_esp(inner_esp), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .gp_fault(gp_fault), .new_cpl(new_cpl), .new_cs(new_cs),
    .new_eip(new_eip), .new_eflags(new_eflags), .new_ss(new_ss),
    .new_esp(new_esp)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  // monitor state, sampled at the falling edge
  logic [31:0] mon_addr [0:15];
  logic [31:0] mon_data [0:15];
  int mon_n = 0, done_cnt = 0, fault_cnt = 0, stall_cnt = 0;
  int last_wr_cyc = 0, done_cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 wr_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (wr_valid && wr_ready && mon_n < 16) begin
      mon_addr[mon_n] = wr_addr;
      mon_data[mon_n] = wr_data;
      mon_n = mon_n + 1;
      last_wr_cyc = cyc;
    end
    if (wr_valid && !wr_ready) stall_cnt = stall_cnt + 1;
    if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
    if (gp_fault) fault_cnt = fault_cnt + 1;
  end

  initial begin
    #1_000_000;
    n_errors = n_errors + 1;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_errors = n_errors + 1;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_n = 0; done_cnt = 0; fault_cnt = 0; stall_cnt = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done_cnt > 0 || fault_cnt > 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_valid && !busy, "R1 idle after reset", {30'b0, wr_valid, busy}, 32'h0);
    chk(!done && !gp_fault, "R1 no pulses after reset", {30'b0, done, gp_fault}, 32'h0);
    chk(new_eip == 0 && new_esp == 0 && new_cpl == 0 && new_cs == 0,
        "R1 results zero", new_eip | new_esp, 32'h0);
  endtask

  // Run one entry with the globals and compare against a frame built here.
  task automatic t_entry(input string name, input bit stall, input bit restart);
    logic [31:0] ew [0:5];
    int   en;
    bit   inner;
    logic [31:0] sp, flags_exp;
    logic [15:0] ss_exp;
    inner = (gate_dpl < cur_cpl);
    en = 0;
    if (inner) begin
      ew[en] = {16'h0, cur_ss}; en++;
      ew[en] = cur_esp;         en++;
    end
    ew[en] = cur_eflags;                        en++;
    ew[en] = {16'h0, cur_cs[15:2], cur_cpl};    en++;
    ew[en] = cur_eip;                           en++;
    if (has_err) begin ew[en] = err_code; en++; end
    sp = inner ? inner_esp : cur_esp;
    ss_exp = inner ? inner_ss : cur_ss;
    flags_exp = gate_is_trap ? cur_eflags : (cur_eflags & ~32'h200);

    clear_mon();
    stall_mode = stall;
    pulse_start();
    if (restart) begin
      // R10: second start with altered inputs while busy
      @(posedge clk); #1;
      cur_eip = 32'hDEAD_0000; gate_eip = 32'h0BAD_0000; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    wait_end();
    stall_mode = 1'b0;

    chk(mon_n == en, {name, " frame length (R3/R4/R5)"}, mon_n, en);
    for (int k = 0; k < 6; k++) begin
      if (k < en && k < mon_n) begin
        chk(mon_addr[k] == sp - 32'(4 * (k + 1)), {name, " R8 word address"}, mon_addr[k], sp - 32'(4 * (k + 1)));
        chk(mon_data[k] == ew[k], {name, " R6 frame word"}, mon_data[k], ew[k]);
      end
    end
    chk(done_cnt == 1, {name, " R9 single done"}, done_cnt, 1);
    chk(done_cyc == last_wr_cyc + 1, {name, " R9 done timing"}, done_cyc, last_wr_cyc + 1);
    chk(new_cpl == gate_dpl && new_cs == gate_cs, {name, " R9 cpl/cs"}, {new_cpl, new_cs}, {gate_dpl, gate_cs});
    chk(new_esp == sp - 32'(4 * en), {name, " R9 new_esp"}, new_esp, sp - 32'(4 * en));
    chk(new_ss == ss_exp, {name, " R9 new_ss"}, new_ss, ss_exp);
    chk(new_eflags == flags_exp, {name, " R7 new flags"}, new_eflags, flags_exp);
    if (stall) chk(stall_cnt > 0, {name, " R8 stalls seen"}, stall_cnt, 1);
  endtask

  initial begin
    t_reset();

    // R3 + R7: same level, interrupt gate, IF set
    gate_is_trap = 0; gate_dpl = 2'd0; cur_cpl = 2'd0;
    gate_cs = 16'h0008; gate_eip = 32'h0010_2000;
    cur_ss = 16'h0010; cur_esp = 32'h0000_8000; cur_eflags = 32'h0000_0246;
    cur_cs = 16'h0008; cur_eip = 32'h0040_1234; has_err = 0;
    inner_ss = 16'h0030; inner_esp = 32'h0009_0000;
    t_entry("R3 same-level", 1'b0, 1'b0);
    chk(new_eip == 32'h0010_2000, "R9 new_eip", new_eip, 32'h0010_2000);

    // R4 + R5 + R7: inward switch, trap gate, error code, IF kept
    gate_is_trap = 1; gate_dpl = 2'd0; cur_cpl = 2'd3;
    gate_cs = 16'h0018; gate_eip = 32'h0020_0100;
    cur_ss = 16'h002B; cur_esp = 32'h7FFF_FF00; cur_eflags = 32'h0000_3202;
    cur_cs = 16'h0023; cur_eip = 32'h0804_8ABC; has_err = 1; err_code = 32'h0000_0014;
    inner_ss = 16'h0010; inner_esp = 32'h00C0_0000;
    t_entry("R4 inner trap err", 1'b0, 1'b0);

    // R8 + R10 + R4: inward switch with stalls and a repeated start
    gate_is_trap = 0; gate_dpl = 2'd1; cur_cpl = 2'd2; has_err = 0;
    gate_cs = 16'h0049; gate_eip = 32'h0030_0000;
    cur_ss = 16'h005A; cur_esp = 32'h0012_3450; cur_eflags = 32'h0000_0202;
    cur_cs = 16'h0061; cur_eip = 32'h0000_7777;
    inner_ss = 16'h0051; inner_esp = 32'h00A0_0010;
    t_entry("R10 stalled restart", 1'b1, 1'b0);
    // restart variant: expected frame is computed before inputs change
    gate_eip = 32'h0030_0000; cur_eip = 32'h0000_7777;
    begin
      logic [31:0] eip_hold;
      eip_hold = gate_eip;
      clear_mon();
      stall_mode = 1'b1;
      pulse_start();
      @(posedge clk); #1;
      cur_eip = 32'hDEAD_0000; gate_eip = 32'h0BAD_0000; gate_dpl = 2'd3; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      wait_end();
      stall_mode = 1'b0;
      chk(mon_n == 5 && fault_cnt == 0, "R10 second start ignored (length)", mon_n, 5);
      chk(mon_n == 5 && mon_data[4] == 32'h0000_7777, "R10 captured eip kept", mon_data[4], 32'h0000_7777);
      chk(new_eip == eip_hold && new_cpl == 2'd1, "R10 captured gate kept", new_eip, eip_hold);
      chk(done_cnt == 1, "R10 one completion", done_cnt, 1);
    end

    // R2: outward target faults, nothing written, results held
    gate_is_trap = 0; gate_dpl = 2'd2; cur_cpl = 2'd1; gate_eip = 32'h5555_5555;
    clear_mon();
    pulse_start();
    wait_end();
    chk(fault_cnt == 1, "R2 single fault pulse", fault_cnt, 1);
    chk(mon_n == 0, "R2 no writes", mon_n, 0);
    chk(done_cnt == 0, "R2 no done", done_cnt, 0);
    chk(new_eip == 32'h0030_0000 && new_cpl == 2'd1, "R2 results unchanged", new_eip, 32'h0030_0000);

    // R3 + R5 + R7: same level, trap gate, error code, IF clear stays clear
    gate_is_trap = 1; gate_dpl = 2'd3; cur_cpl = 2'd3;
    gate_cs = 16'h0073; gate_eip = 32'h0000_4000;
    cur_ss = 16'h007B; cur_esp = 32'h0000_1000; cur_eflags = 32'h0000_0086;
    cur_cs = 16'h0070; cur_eip = 32'h0000_2222; has_err = 1; err_code = 32'hFFFF_0000;
    t_entry("R5 same-level err", 1'b0, 1'b0);

    // R7: interrupt gate with IF set at inner level, error code
    gate_is_trap = 0; gate_dpl = 2'd0; cur_cpl = 2'd1; has_err = 1; err_code = 32'h0000_0008;
    cur_eflags = 32'hFFFF_FFFF;
    t_entry("R7 interrupt gate clears IF", 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule